// File: doc/BRIEF.md
# Dual-Slot Memory Access Scheduler

This block takes two memory instructions that were issued together as one execution set and plays out their memory accesses over the following cycles. Each slot is either a plain move (one read or one write) or a bit-set operation. A bit-set reads a word, ORs an immediate mask into it, and writes the word back. When an address must be computed before use, that slot starts one cycle later. The scheduler lays out every access on a per-cycle timeline. It finds accesses from the two slots that would collide on a memory bank in the same cycle, and it pushes the second slot later until no collision remains.

Each cycle of the set drives one access port per slot toward a simple memory. The scheduler captures read data and forms the written-back word for a bit-set. When the set is done it reports the number of stall cycles it inserted, a contention flag, the total length of the set and the final data word of each slot.

Top module: `mem_pair_sched`

## Requirements
- R1: While reset is held and after it is released, busy, done and both access-valid outputs are 0.
- R2: Mode code 0 (absolute) and 1 (register-indirect) place a slot's first access in cycle 1. Mode code 2 (needs address pre-computation) places it in cycle 2. The cycle after an accepted start shows cycle number 1.
- R3: Op code 2 (bit-set) reads its address in its first access cycle. In the next cycle it writes the same address with the read word ORed with the slot mask.
- R4: Op code 0 (move read) performs one read, and its result is the word read. Op code 1 (move write) performs one write of the slot's write data, and its result is that data.
- R5: Two accesses conflict only when all of these hold: they come from different slots, they fall in the same cycle, their addresses match in bits [3:2], and at least one of them is a write. Two reads never conflict, and accesses in different cycles never conflict.
- R6: While the schedule has a conflict, the whole of slot 1 moves one cycle later and the stall count rises by one. The contention flag is 1 exactly when the stall count is nonzero. The slot 0 timing never moves.
- R7: The total equals the last access cycle of the resolved schedule. Busy covers cycles 1 to total. Done is a one-clock pulse in the cycle that follows the last access.
- R8: A start while busy is ignored: the running schedule, its total and its results are unchanged, and no new set begins afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept the execution set on the slot inputs |
| op_i | input | 2x2 | Per-slot operation code (0 read, 1 write, 2 bit-set) |
| mode_i | input | 2x2 | Per-slot addressing mode (0 absolute, 1 indirect, 2 pre-computed) |
| addr_i | input | 2xAW | Per-slot effective address |
| wdata_i | input | 2xDW | Per-slot move write data |
| mask_i | input | 2xDW | Per-slot bit-set mask |
| mem_vld_o | output | 2 | Per-slot access valid in this cycle |
| mem_we_o | output | 2 | Per-slot write enable |
| mem_addr_o | output | 2xAW | Per-slot access address |
| mem_wdata_o | output | 2xDW | Per-slot write data |
| mem_rdata_i | input | 2xDW | Per-slot read data, combinational from memory |
| busy_o | output | 1 | Execution set in progress |
| cycle_o | output | CW | Current cycle number of the set |
| done_o | output | 1 | One-clock completion pulse |
| contention_o | output | 1 | At least one stall was inserted |
| stalls_o | output | CW | Number of stall cycles inserted |
| total_o | output | CW | Length of the resolved set in cycles |
| result_o | output | 2xDW | Per-slot final data word |

## Verification
A bit-set read or write in slot 0 can fall in the same cycle as the read or write of slot 1. The stimulus provokes this by pairing the two slots with equal bank bits and chosen address modes, so that the unshifted timelines overlap. Some cases need one shift and some need two, because a shift can move a write onto the other slot's write-back. Each access on the ports is checked in order against the expected cycle, direction, address and data. Cases with the same timing but different bank bits, and cases with two same-bank reads in one cycle, show that no stall is inserted when the rule does not call for one.

// File: rtl/mem_sched_pkg.sv
package mem_sched_pkg;
   typedef enum logic [1:0] {
      OP_RD   = 2'd0,
      OP_WR   = 2'd1,
      OP_BSET = 2'd2,
      OP_RSV  = 2'd3
   } slot_op_e;

   typedef enum logic [1:0] {
      AM_ABS  = 2'd0,
      AM_IND  = 2'd1,
      AM_PRE  = 2'd2,
      AM_RSV  = 2'd3
   } addr_mode_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer
   import mem_sched_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic [1:0]    op_i,
   input  logic [1:0]    mode_i,
   output logic [CW-1:0] first_o,
   output logic          pair_o,
   output logic          first_wr_o
);
   slot_op_e   op;
   addr_mode_e md;

   always_comb begin
      op = slot_op_e'(op_i);
      md = addr_mode_e'(mode_i);
      // address ready at once: cycle 1; pre-computed address costs one cycle
      first_o    = (md == AM_ABS || md == AM_IND) ? CW'(1) : CW'(2);
      pair_o     = (op == OP_BSET);
      first_wr_o = (op == OP_WR);
   end
endmodule

// File: rtl/clash_resolver.sv
module clash_resolver #(
   parameter int CW        = 4,
   parameter int MAX_SHIFT = 3
) (
   input  logic [CW-1:0] t_a_i,
   input  logic          pair_a_i,
   input  logic          wr_a_i,
   input  logic [CW-1:0] t_b_i,
   input  logic          pair_b_i,
   input  logic          wr_b_i,
   input  logic          same_bank_i,
   output logic [CW-1:0] shift_o
);
   function automatic logic clash(input logic [CW-1:0] ta, input logic pa, input logic wa,
                                  input logic [CW-1:0] tb, input logic pb, input logic wb,
                                  input logic [CW-1:0] sh);
      logic hit;
      logic [CW-1:0] ca, cb;
      logic xa, xb;
      hit = 1'b0;
      for (int i = 0; i < 2; i++) begin
         for (int j = 0; j < 2; j++) begin
            ca = ta + CW'(i);
            cb = tb + sh + CW'(j);
            xa = (i == 1) || wa;
            xb = (j == 1) || wb;
            if ((i == 0 || pa) && (j == 0 || pb) && (ca == cb) && (xa || xb))
               hit = 1'b1;
         end
      end
      return hit;
   endfunction

   logic found;

   always_comb begin
      shift_o = CW'(MAX_SHIFT);
      found   = 1'b0;
      if (!same_bank_i) begin
         shift_o = '0;
      end else begin
         for (int k = 0; k <= MAX_SHIFT; k++) begin
            if (!found && !clash(t_a_i, pair_a_i, wr_a_i, t_b_i, pair_b_i, wr_b_i, CW'(k))) begin
               shift_o = CW'(k);
               found   = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mem_pair_sched.sv
module mem_pair_sched #(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int BANK_LSB  = 2,
   parameter int BANK_BITS = 2,
   parameter int CW        = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [1:0][1:0]          op_i,
   input  logic [1:0][1:0]          mode_i,
   input  logic [1:0][AW-1:0]       addr_i,
   input  logic [1:0][DW-1:0]       wdata_i,
   input  logic [1:0][DW-1:0]       mask_i,
   output logic [1:0]               mem_vld_o,
   output logic [1:0]               mem_we_o,
   output logic [1:0][AW-1:0]       mem_addr_o,
   output logic [1:0][DW-1:0]       mem_wdata_o,
   input  logic [1:0][DW-1:0]       mem_rdata_i,
   output logic                     busy_o,
   output logic [CW-1:0]            cycle_o,
   output logic                     done_o,
   output logic                     contention_o,
   output logic [CW-1:0]            stalls_o,
   output logic [CW-1:0]            total_o,
   output logic [1:0][DW-1:0]       result_o
);
   localparam int NSLOT     = 2;
   localparam int MAX_SHIFT = 3;
   localparam int MAX_LAST  = 2 + 1 + MAX_SHIFT;

   if (BANK_LSB + BANK_BITS > AW) begin : g_bad_bank
      $error("bank field lies outside the address");
   end
   if ((1 << CW) <= MAX_LAST) begin : g_bad_cw
      $error("cycle counter too narrow for the longest schedule");
   end

   logic [CW-1:0] t0_w   [NSLOT];
   logic          pair_w [NSLOT];
   logic          fwr_w  [NSLOT];
   logic [CW-1:0] last_w [NSLOT];
   logic [CW-1:0] shift_w;
   logic          same_bank;
   logic          accept;

   logic          busy_q, done_q;
   logic [CW-1:0] cyc_q, total_q, stall_q;

   assign accept    = start_i && !busy_q;
   assign same_bank = addr_i[0][BANK_LSB +: BANK_BITS] == addr_i[1][BANK_LSB +: BANK_BITS];

   for (genvar g = 0; g < NSLOT; g++) begin : g_timer
      slot_timer #(.CW(CW)) i_timer (
         .op_i       (op_i[g]),
         .mode_i     (mode_i[g]),
         .first_o    (t0_w[g]),
         .pair_o     (pair_w[g]),
         .first_wr_o (fwr_w[g])
      );
   end

   clash_resolver #(.CW(CW), .MAX_SHIFT(MAX_SHIFT)) i_resolver (
      .t_a_i       (t0_w[0]),
      .pair_a_i    (pair_w[0]),
      .wr_a_i      (fwr_w[0]),
      .t_b_i       (t0_w[1]),
      .pair_b_i    (pair_w[1]),
      .wr_b_i      (fwr_w[1]),
      .same_bank_i (same_bank),
      .shift_o     (shift_w)
   );

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [CW-1:0] first_d, first_q;
      logic [AW-1:0] addr_q;
      logic [DW-1:0] wdata_q, mask_q, rd_q;
      logic          pair_q, fwr_q;
      logic          hit_a, hit_b;

      if (g == 0) begin : g_fixed
         assign first_d = t0_w[g];
      end else begin : g_moved
         assign first_d = t0_w[g] + shift_w;
      end
      assign last_w[g] = first_d + CW'(pair_w[g]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            first_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            rd_q    <= '0;
            pair_q  <= 1'b0;
            fwr_q   <= 1'b0;
         end else if (accept) begin
            first_q <= first_d;
            addr_q  <= addr_i[g];
            wdata_q <= wdata_i[g];
            mask_q  <= mask_i[g];
            pair_q  <= pair_w[g];
            fwr_q   <= fwr_w[g];
         end else if (hit_a && !fwr_q) begin
            rd_q <= mem_rdata_i[g];
         end
      end

      assign hit_a = busy_q && (cyc_q == first_q);
      assign hit_b = busy_q && pair_q && (cyc_q == first_q + CW'(1));

      assign mem_vld_o[g]   = hit_a || hit_b;
      assign mem_we_o[g]    = hit_b || (hit_a && fwr_q);
      assign mem_addr_o[g]  = addr_q;
      assign mem_wdata_o[g] = hit_b ? (rd_q | mask_q) : wdata_q;
      assign result_o[g]    = pair_q ? (rd_q | mask_q) : (fwr_q ? wdata_q : rd_q);

      // R3: a bit-set read is followed by its write-back to the same address
      p_bset_writeback_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_vld_o[g] && !mem_we_o[g] && pair_q) |=>
            (mem_vld_o[g] && mem_we_o[g] && $stable(mem_addr_o[g])));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cyc_q   <= '0;
         total_q <= '0;
         stall_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            cyc_q   <= CW'(1);
            stall_q <= shift_w;
            total_q <= (last_w[0] > last_w[1]) ? last_w[0] : last_w[1];
         end else if (busy_q) begin
            if (cyc_q == total_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               cyc_q  <= '0;
            end else begin
               cyc_q <= cyc_q + CW'(1);
            end
         end
      end
   end

   assign busy_o       = busy_q;
   assign cycle_o      = cyc_q;
   assign done_o       = done_q;
   assign stalls_o     = stall_q;
   assign total_o      = total_q;
   assign contention_o = (stall_q != '0);

   // R5: no same-cycle, same-bank pair of accesses involving a write reaches the ports
   p_no_bank_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_vld_o[0] && mem_vld_o[1] &&
        (mem_addr_o[0][BANK_LSB +: BANK_BITS] == mem_addr_o[1][BANK_LSB +: BANK_BITS]) &&
        (mem_we_o[0] || mem_we_o[1])));

   // R2: an accepted start opens cycle 1
   p_start_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && cycle_o == CW'(1)));

   // R7: done lasts one clock and follows the last scheduled cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(cycle_o) == total_o));

   // R8: a start during a running set leaves its summary untouched
   p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> ($stable(total_o) && $stable(stalls_o)));
endmodule

// File: tb/test_mem_pair_sched.sv
`timescale 1ns/1ps
module test_mem_pair_sched;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [1:0][1:0]      op, mode;
   logic [1:0][AW-1:0]   addr;
   logic [1:0][DW-1:0]   wdata, mask;
   logic [1:0]           vld, we;
   logic [1:0][AW-1:0]   maddr;
   logic [1:0][DW-1:0]   mwdata, mrdata;
   logic                 busy, done, cont;
   logic [CW-1:0]        cyc, stalls, total;
   logic [1:0][DW-1:0]   result;

   always #2.5 clk = ~clk;

   mem_pair_sched #(.AW(AW), .DW(DW), .BANK_LSB(2), .BANK_BITS(2), .CW(CW)) i_mem_pair_sched (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .op_i(op), .mode_i(mode), .addr_i(addr), .wdata_i(wdata), .mask_i(mask),
      .mem_vld_o(vld), .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
      .mem_rdata_i(mrdata),
      .busy_o(busy), .cycle_o(cyc), .done_o(done), .contention_o(cont),
      .stalls_o(stalls), .total_o(total), .result_o(result)
   );

   logic [DW-1:0] mem [64];
   always_comb begin
      mrdata[0] = mem[maddr[0][5:0]];
      mrdata[1] = mem[maddr[1][5:0]];
   end
   always @(posedge clk) begin
      for (int s = 0; s < 2; s++)
         if (rst_n && vld[s] && we[s]) mem[maddr[s][5:0]] <= mwdata[s];
   end

   int n_total = 0;
   int n_bad   = 0;

   typedef struct {
      int            c;
      int            slot;
      bit            w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         req;
   } acc_t;
   acc_t sb[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected accesses in cycle/slot order
   always @(negedge clk) begin
      if (rst_n && busy) begin
         for (int s = 0; s < 2; s++) begin
            if (vld[s]) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R5", "unexpected access slot", 32'(s), 32'hFFFF);
               end else begin
                  acc_t e;
                  e = sb.pop_front();
                  check(e.c == int'(cyc) && e.slot == s, e.req, "access cycle",
                        32'(cyc), 32'(e.c));
                  check(e.w == we[s] && e.a == maddr[s] && (!e.w || e.d == mwdata[s]),
                        e.req, "access dir/addr/data",
                        {we[s], 7'd0, maddr[s][7:0], mwdata[s]},
                        {e.w, 7'd0, e.a[7:0], e.d});
               end
            end
         end
      end
   end

   task automatic run_set(input logic [1:0] o0, input logic [1:0] m0, input logic [15:0] a0,
                          input logic [15:0] w0, input logic [15:0] k0,
                          input logic [1:0] o1, input logic [1:0] m1, input logic [15:0] a1,
                          input logic [15:0] w1, input logic [15:0] k1,
                          input int stall, input bit poke, input string req);
      int            t [2];
      logic [1:0]    ops [2];
      logic [15:0]   ad [2];
      logic [15:0]   wd [2];
      logic [15:0]   km [2];
      logic [15:0]   exp_res [2];
      int            tot;
      int            waited;
      acc_t          it;
      ops[0] = o0; ops[1] = o1; ad[0] = a0; ad[1] = a1;
      wd[0] = w0; wd[1] = w1; km[0] = k0; km[1] = k1;
      t[0] = (m0 == 2'd2) ? 2 : 1;                 // R2
      t[1] = ((m1 == 2'd2) ? 2 : 1) + stall;       // R6
      tot = 0;
      for (int s = 0; s < 2; s++) begin
         int l;
         l = t[s] + ((ops[s] == 2'd2) ? 1 : 0);
         if (l > tot) tot = l;
         exp_res[s] = (ops[s] == 2'd1) ? wd[s] :
                      (ops[s] == 2'd2) ? (mem[ad[s][5:0]] | km[s]) : mem[ad[s][5:0]];
      end
      for (int c = 1; c <= 8; c++) begin
         for (int s = 0; s < 2; s++) begin
            it.slot = s; it.c = c; it.a = ad[s]; it.req = req;
            if (c == t[s]) begin
               it.w = (ops[s] == 2'd1);
               it.d = wd[s];
               sb.push_back(it);
            end else if (ops[s] == 2'd2 && c == t[s] + 1) begin
               it.w = 1'b1;
               it.d = mem[ad[s][5:0]] | km[s];   // R3
               sb.push_back(it);
            end
         end
      end
      @(negedge clk);
      op[0] = o0; mode[0] = m0; addr[0] = a0; wdata[0] = w0; mask[0] = k0;
      op[1] = o1; mode[1] = m1; addr[1] = a1; wdata[1] = w1; mask[1] = k1;
      start = 1'b1;
      @(negedge clk);
      if (poke) begin
         op[0] = 2'd1; addr[0] = 16'h003F; mode[1] = 2'd0; addr[1] = 16'h0001;
         @(negedge clk);
      end
      start = 1'b0;
      waited = 0;
      while (!done && waited < 40) begin
         @(negedge clk);
         waited++;
      end
      check(done == 1'b1, "R7", "done seen", 32'(done), 32'd1);
      check(int'(stalls) == stall, "R6", "stall count", 32'(stalls), 32'(stall));
      check(cont == (stall != 0), "R6", "contention flag", 32'(cont), 32'(stall != 0));
      check(int'(total) == tot, "R7", "total cycles", 32'(total), 32'(tot));
      check(sb.size() == 0, req, "accesses missing", 32'(sb.size()), 32'd0);
      sb.delete();
      for (int s = 0; s < 2; s++)
         check(result[s] == exp_res[s], (ops[s] == 2'd2) ? "R3" : "R4", "result",
               32'(result[s]), 32'(exp_res[s]));
      @(negedge clk);
      check(done == 1'b0, "R7", "done one clock", 32'(done), 32'd0);
      check(busy == 1'b0, poke ? "R8" : "R7", "idle after done", 32'(busy), 32'd0);
      if (poke) begin
         @(negedge clk);
         check(busy == 1'b0 && int'(total) == tot, "R8", "no late start",
               {busy, 15'd0, 12'd0, total}, {16'd0, 12'd0, 4'(tot)});
      end
   endtask

   initial begin
      #1000000;
      check(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'(16'h0A00 + i * 16'h0123);
      op = '0; mode = '0; addr = '0; wdata = '0; mask = '0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && vld == 2'b00, "R1", "state in reset",
            {busy, done, vld}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && vld == 2'b00, "R1", "state after reset",
            {busy, done, vld}, 32'd0);
      // R2/R4: write at cycle 1, pre-computed read at cycle 2, no conflict
      run_set(2'd1, 2'd1, 16'h0010, 16'h1234, 16'h0, 2'd0, 2'd2, 16'h0014, 16'h0, 16'h0, 0, 0, "R2");
      // R5/R6: bit-set read vs write in cycle 1, then write vs write in cycle 2
      run_set(2'd2, 2'd1, 16'h0020, 16'h0, 16'h0008, 2'd1, 2'd0, 16'h0030, 16'h5555, 16'h0, 2, 0, "R6");
      // R6: write-back vs pre-computed write in cycle 2
      run_set(2'd2, 2'd1, 16'h0008, 16'h0, 16'h0010, 2'd1, 2'd2, 16'h0018, 16'h2222, 16'h0, 1, 0, "R6");
      // R5: same bank but different cycles
      run_set(2'd2, 2'd2, 16'h0004, 16'h0, 16'h0080, 2'd1, 2'd0, 16'h0024, 16'h7777, 16'h0, 0, 0, "R5");
      // R5: two reads in one cycle, same bank
      run_set(2'd0, 2'd0, 16'h000C, 16'h0, 16'h0, 2'd0, 2'd1, 16'h001C, 16'h0, 16'h0, 0, 0, "R5");
      // R5: two writes in one cycle, different banks
      run_set(2'd1, 2'd0, 16'h0000, 16'hAAAA, 16'h0, 2'd1, 2'd0, 16'h0004, 16'hBBBB, 16'h0, 0, 0, "R5");
      // R5/R6: two writes in one cycle, same bank
      run_set(2'd1, 2'd0, 16'h0000, 16'hCCCC, 16'h0, 2'd1, 2'd0, 16'h0010, 16'hDDDD, 16'h0, 1, 0, "R6");
      // R3/R6: two bit-sets, same bank, need two shifts
      run_set(2'd2, 2'd1, 16'h0028, 16'h0, 16'h0101, 2'd2, 2'd1, 16'h0038, 16'h0, 16'h8000, 2, 0, "R3");
      // R6: pre-computed read vs bit-set write-back
      run_set(2'd0, 2'd2, 16'h002C, 16'h0, 16'h0, 2'd2, 2'd0, 16'h003C, 16'h0, 16'h00F0, 1, 0, "R6");
      // R8: start held while busy with altered inputs
      run_set(2'd2, 2'd1, 16'h0020, 16'h0, 16'h4000, 2'd1, 2'd0, 16'h0030, 16'h9999, 16'h0, 2, 1, "R8");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule